// File: doc/BRIEF.md
# Debug Interrupt Injection Bank

This block is a small register bank mapped into a processor's data address space, used by simulation test programs to raise hardware interrupt lines at a chosen point in program flow. Each of six interrupt lines has its own down-counter. Software arms a line by writing a delay to that line's register. The delay is counted in retired instructions, taken from a one-cycle retire strobe, so clock cycles lost to bus or memory stalls do not shift the moment of injection.

When a line's count runs out, its interrupt output goes high and stays high until software writes that line's register again. That write either re-arms the line or, with a value of zero, clears and disarms it. Lines given the same delay fire on the same instruction. A read port returns the remaining count of any line, so a program can check that a countdown is in progress. The two software interrupt lines of the processor are not driven by this block.

Top module: `dbg_irq_inject`

## Requirements
- R1: After reset every interrupt output is 0 and every line reads back a count of 0.
- R2: A write with `bus_we` high to address BASE_ADDR + 4*n, for n from 0 to 5, loads line n's count with the low 16 bits of `bus_wdata` and clears `irq_o[n]`. A value with any of bits 31:16 set loads 16'hFFFF. Other lines are left unchanged.
- R3: A line loaded with count V > 0 raises `irq_o[n]` on the clock edge that samples its V-th later `retire_i` pulse, so the bit is visible in the following cycle.
- R4: In cycles with `retire_i` low and no write to the line, its count and its interrupt bit do not change.
- R5: Once raised, `irq_o[n]` stays high and the count stays 0 through any number of further retire pulses, until line n is written.
- R6: Writing 0 to a line disarms it. Its count reads 0, its interrupt bit is cleared, and it does not fire on later retire pulses.
- R7: Lines loaded with equal delays raise their interrupt bits on the same clock edge.
- R8: A write is ignored when its address is below BASE_ADDR, at or above BASE_ADDR + 24, or has bits 1:0 not equal to 00. Counts and interrupt bits are unchanged.
- R9: When a write to line n and a retire pulse fall in the same cycle, line n takes the written value with no decrement in that cycle. The other lines still count the pulse.
- R10: `rd_data` returns the count of the line addressed by `rd_addr`, zero-extended and decoded like R8. An unmapped read address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address of the write |
| bus_wdata | input | 32 | Write data (delay value) |
| bus_we | input | 1 | Write strobe, one cycle per write |
| rd_addr | input | 32 | Byte address of the read |
| rd_data | output | 32 | Remaining count of the addressed line |
| retire_i | input | 1 | One-cycle pulse per retired instruction |
| irq_o | output | 6 | Injected hardware interrupt lines |

## Verification
The assertions take for granted that `retire_i` and `bus_we` are known, single-bit strobes sampled once per clock, and that a write lasts exactly one cycle. The hold and no-effect properties depend on the stimulus not changing the address or data while the strobe is high. The bench changes inputs only at the falling edge and lowers both strobes shortly after each rising edge. Random addresses are drawn from the six mapped words and a fixed set of unmapped, misaligned and out-of-window addresses, so every write is either a clean hit or a clean miss.

// File: rtl/irq_inject_pkg.sv
`timescale 1ns/1ps
package irq_inject_pkg;
   localparam int WORD_BYTES = 4;

   function automatic int idx_width(input int lines);
      return (lines > 1) ? $clog2(lines) : 1;
   endfunction

   function automatic int window_bytes(input int lines);
      return lines * WORD_BYTES;
   endfunction
endpackage

// File: rtl/reg_window_decode.sv
`timescale 1ns/1ps
module reg_window_decode
   import irq_inject_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                NUM_LINES = 6,
   parameter int                IDX_W     = 3,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(window_bytes(NUM_LINES));

   logic [ADDR_W-1:0] offset;
   logic              above_base;
   logic              in_span;
   logic              aligned;

   assign offset     = addr_i - BASE_ADDR;
   assign above_base = (addr_i >= BASE_ADDR);
   assign in_span    = (offset < SPAN);
   assign aligned    = (offset[1:0] == 2'b00);
   assign hit_o      = above_base && in_span && aligned;
   assign idx_o      = offset[IDX_W+1:2];
endmodule

// File: rtl/irq_line_timer.sv
`timescale 1ns/1ps
module irq_line_timer #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              tick_i,
   output logic [CNT_W-1:0]  count_o,
   output logic              irq_o
);
   logic [CNT_W-1:0] load_val;

   generate
      if (DATA_W > CNT_W) begin : g_saturate
         assign load_val = (|load_data_i[DATA_W-1:CNT_W]) ? {CNT_W{1'b1}}
                                                           : load_data_i[CNT_W-1:0];
      end else begin : g_direct
         assign load_val = load_data_i[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o <= '0;
         irq_o   <= 1'b0;
      end else if (load_i) begin
         count_o <= load_val;
         irq_o   <= 1'b0;
      end else if (tick_i && (count_o != '0)) begin
         count_o <= count_o - 1'b1;
         if (count_o == CNT_W'(1)) irq_o <= 1'b1;
      end
   end

   // R2 R6 R9: a write takes effect in full on the next cycle
   a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (count_o == $past(load_val)) && !irq_o);

   // R4: idle cycles leave the line untouched
   a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !tick_i) |=> $stable(count_o) && $stable(irq_o));

   // R3: the last pulse fires the line
   a_r3_fire_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && tick_i && (count_o == CNT_W'(1))) |=> irq_o);

   // R5: a raised line stays raised until written
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !load_i) |=> irq_o);

   // R5: a raised line has nothing left to count
   a_r5_spent_count: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (count_o == '0));
endmodule

// File: rtl/dbg_irq_inject.sv
`timescale 1ns/1ps
module dbg_irq_inject
   import irq_inject_pkg::*;
#(
   parameter int                NUM_LINES = 6,
   parameter int                CNT_W     = 16,
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2001_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   input  logic                 retire_i,
   output logic [NUM_LINES-1:0] irq_o
);
   localparam int IDX_W  = idx_width(NUM_LINES);
   localparam int SPAN_W = IDX_W + 2;

   generate
      if (NUM_LINES < 1 || NUM_LINES > 64) begin : g_bad_lines
         $error("NUM_LINES out of range");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must be between 1 and DATA_W");
      end
      if (ADDR_W < SPAN_W + 1) begin : g_bad_addr
         $error("ADDR_W too small for register window");
      end
      if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
         $error("BASE_ADDR must be word aligned");
      end
   endgenerate

   logic             wr_hit;
   logic [IDX_W-1:0] wr_idx;
   logic             rd_hit;
   logic [IDX_W-1:0] rd_idx;
   logic [CNT_W-1:0] line_cnt [NUM_LINES];

   reg_window_decode #(
      .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)
   ) u_wr_dec (
      .addr_i(bus_addr), .hit_o(wr_hit), .idx_o(wr_idx)
   );

   reg_window_decode #(
      .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)
   ) u_rd_dec (
      .addr_i(rd_addr), .hit_o(rd_hit), .idx_o(rd_idx)
   );

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         logic sel;
         assign sel = bus_we && wr_hit && (wr_idx == IDX_W'(i));

         irq_line_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_timer (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (sel),
            .load_data_i(bus_wdata),
            .tick_i     (retire_i),
            .count_o    (line_cnt[i]),
            .irq_o      (irq_o[i])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_hit) begin
         for (int i = 0; i < NUM_LINES; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = DATA_W'(line_cnt[i]);
         end
      end
   end

   // R8: a missed write with no retire leaves every line as it was
   a_r8_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !wr_hit && !retire_i) |=> $stable(irq_o));

   // R4: with no strobe at all, the interrupt vector cannot move
   a_r4_vector_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && !retire_i) |=> $stable(irq_o));
endmodule

// File: tb/tb_dbg_irq_inject.sv
`timescale 1ns/1ps
module tb_dbg_irq_inject;
   localparam int          N    = 6;
   localparam logic [31:0] BASE = 32'h2001_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic        retire_i = 1'b0;
   logic [N-1:0] irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic [15:0]  m_cnt [N];
   logic [N-1:0] m_irq;

   always #2.5 clk = ~clk;

   dbg_irq_inject dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .rd_addr(rd_addr), .rd_data(rd_data),
      .retire_i(retire_i), .irq_o(irq_o)
   );

   function automatic int line_of(input logic [31:0] a);
      logic [31:0] off;
      off = a - BASE;
      if (a < BASE || off >= 32'd24 || off[1:0] != 2'b00) return -1;
      return int'(off >> 2);
   endfunction

   function automatic logic [15:0] sat16(input logic [31:0] d);
      return (d[31:16] != 16'h0) ? 16'hFFFF : d[15:0];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      check({tag, " irq"}, 32'(irq_o), 32'(m_irq));
      for (int i = 0; i < N; i++) begin
         rd_addr = BASE + 32'(4 * i);
         #0.2;
         check({tag, " cnt"}, rd_data, 32'(m_cnt[i]));
      end
   endtask

   // One cycle: drive at negedge, update model after posedge, check, back to negedge.
   task automatic step(input bit we, input logic [31:0] a, input logic [31:0] d,
                       input bit ret, input string tag);
      int hit;
      bus_we = we; bus_addr = a; bus_wdata = d; retire_i = ret;
      @(posedge clk);
      #0.5;
      bus_we = 1'b0; retire_i = 1'b0;
      hit = we ? line_of(a) : -1;
      for (int i = 0; i < N; i++) begin
         if (hit == i) begin
            m_cnt[i] = sat16(d);
            m_irq[i] = 1'b0;
         end else if (ret && m_cnt[i] != 16'h0) begin
            m_cnt[i] = m_cnt[i] - 16'h1;
            if (m_cnt[i] == 16'h0) m_irq[i] = 1'b1;
         end
      end
      check_all(tag);
      @(negedge clk);
   endtask

   task automatic retires(input int k, input string tag);
      for (int j = 0; j < k; j++) step(1'b0, '0, '0, 1'b1, tag);
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] bad_addr [5];
      bad_addr[0] = BASE + 32'd24; bad_addr[1] = BASE + 32'd1;
      bad_addr[2] = BASE - 32'd4;  bad_addr[3] = 32'h2002_0000;
      bad_addr[4] = BASE + 32'd6;
      for (int i = 0; i < N; i++) m_cnt[i] = '0;
      m_irq = '0;
      void'($urandom(32'd1234));

      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R2: load line 2, others untouched; R10 read back
      step(1'b1, BASE + 32'd8, 32'd5, 1'b0, "R2");
      // R4: idle gaps between pulses
      step(1'b0, '0, '0, 1'b0, "R4");
      retires(2, "R3");
      step(1'b0, '0, '0, 1'b0, "R4");
      retires(3, "R3");
      check("R3 fired", 32'(irq_o[2]), 32'd1);
      // R5: sticky
      retires(4, "R5");
      // R2: rewrite clears and reloads; saturation
      step(1'b1, BASE + 32'd8, 32'h0001_0003, 1'b0, "R2");
      check("R2 saturate", 32'(m_cnt[2]), 32'hFFFF);
      // R6: zero disarms
      step(1'b1, BASE + 32'd8, 32'd0, 1'b0, "R6");
      retires(3, "R6");
      // R7: equal delays on lines 0, 3, 5
      step(1'b1, BASE + 32'd0,  32'd3, 1'b0, "R7");
      step(1'b1, BASE + 32'd12, 32'd3, 1'b0, "R7");
      step(1'b1, BASE + 32'd20, 32'd3, 1'b0, "R7");
      retires(2, "R7");
      check("R7 none yet", 32'(irq_o), 32'h0);
      retires(1, "R7");
      check("R7 together", 32'(irq_o), 32'b101001);
      // R8: unmapped writes
      for (int k = 0; k < 5; k++) step(1'b1, bad_addr[k], 32'd7, 1'b0, "R8");
      // R9: write with retire in the same cycle
      step(1'b1, BASE + 32'd4, 32'd4, 1'b0, "R9");
      step(1'b1, BASE + 32'd16, 32'd2, 1'b1, "R9");
      check("R9 no decrement", 32'(m_cnt[4]), 32'd2);
      // R10: unmapped read returns zero
      rd_addr = BASE + 32'd24; #0.2; check("R10 unmapped read", rd_data, 32'h0);
      rd_addr = BASE + 32'd2;  #0.2; check("R10 misaligned read", rd_data, 32'h0);

      // random mix
      for (int t = 0; t < 3000; t++) begin
         logic [31:0] a, d;
         int r;
         r = int'($urandom_range(0, 9));
         a = (r < 8) ? BASE + 32'(4 * $urandom_range(0, N - 1))
                     : bad_addr[$urandom_range(0, 4)];
         r = int'($urandom_range(0, 9));
         d = (r < 2) ? 32'd0 : (r < 9) ? 32'($urandom_range(1, 12)) : $urandom;
         step(($urandom_range(0, 3) == 0), a, d, $urandom_range(0, 1) == 1, "R3/R5/R9");
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule